// File: doc/BRIEF.md
# Receive Flow-Control Threshold Controller

This block decides when a serial receiver should tell the far end to pause or to carry on sending. It holds one 8-bit control value that packs two thresholds, each a 4-bit code in units of four bytes. One threshold is the level at which sending must stop. The other is the level at which sending may restart. Each cycle the block compares the receive FIFO fill count with both levels. It drives a registered, hysteretic halt request that can serve as a ready-to-send style line, together with one-cycle stop and resume strobes for a software pause/continue character generator.

The control value can be written only when both gating inputs from the wider register set are high: an extended-feature enable and a modem-control select. The block makes no check that the two thresholds are in a sensible order. Whatever is stored is used as it stands. Software is expected to program the thresholds before it raises the flow-control enable. While that enable is low, the halt request is forced off and the hysteresis state is cleared.

Top module: `rx_flow_gate`

## Requirements
- R1: After reset, `ctrlValue` reads 0x00, and `haltReq`, `stopPulse` and `resumePulse` are all 0.
- R2: A write with `wrEn`, `extEnable` and `modemSel` all at 1 stores `wrData`, and the new value is visible on `ctrlValue` one clock later. Bits [3:0] hold the halt code and bits [7:4] hold the resume code.
- R3: A write with `extEnable` at 0 or `modemSel` at 0 is ignored: `ctrlValue` keeps its previous value.
- R4: The halt level is 4 × `ctrlValue[3:0]`. With `flowEn` at 1 and the block not halted, `rxCount` >= halt level sets `haltReq` to 1 one clock later, and `stopPulse` is 1 for exactly that one cycle.
- R5: The resume level is 4 × `ctrlValue[7:4]`. Once halted with `flowEn` at 1, `haltReq` stays 1 while `rxCount` is above the resume level. A count at or below the resume level clears `haltReq` one clock later, and `resumePulse` is 1 for exactly that one cycle.
- R6: `flowEn` at 0 forces `haltReq` to 0 one clock later without a `resumePulse`. Because the cleared state is kept, re-enabling with a count between the two levels leaves `haltReq` at 0.
- R7: The thresholds are used as written, with no ordering check. If the resume level is at or above the halt level, a count that meets both sets the halt, releases it the next cycle (with `resumePulse`), then sets it again, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control value |
| wrData | input | 8 | Write data: [7:4] resume code, [3:0] halt code |
| extEnable | input | 1 | Extended-feature enable, write gate |
| modemSel | input | 1 | Modem-control select, write gate |
| rxCount | input | 7 | Current receive FIFO fill count (0 to 64) |
| flowEn | input | 1 | Flow-control enable |
| ctrlValue | output | 8 | Stored control value |
| haltReq | output | 1 | Registered request to stop the far end |
| stopPulse | output | 1 | One-cycle strobe when the halt is raised |
| resumePulse | output | 1 | One-cycle strobe when the halt is released by the count |

## Verification
The hardest situation to reach is a halt that is still latched while the count sits strictly between the two levels, since that is the only place where hysteresis differs from a plain compare. The bench reaches it by programming every ordered pair of codes. For each pair it ramps the count from empty to 64 and back down one byte per cycle, so every count passes through both the halted and the running state. Misordered codes and a disable in the middle of a halt are driven as separate directed sequences.

// File: rtl/rx_flow_pkg.sv
package rx_flow_pkg;

  // Compare results handed from the datapath to the control FSM
  typedef struct packed {
    logic reachHalt;    // count at or above the halt level
    logic reachResume;  // count at or below the resume level
  } thrStrobe_t;

  typedef enum logic {
    FLOW_RUN  = 1'b0,
    FLOW_HOLD = 1'b1
  } flowState_t;

endpackage

// File: rtl/rx_flow_thresh_dp.sv
module rx_flow_thresh_dp
  import rx_flow_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int NIB_W     = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2*NIB_W-1:0]   wrData,
  input  logic                 extEnable,
  input  logic                 modemSel,
  input  logic [CNT_W-1:0]     rxCount,
  output logic [2*NIB_W-1:0]   ctrlValue,
  output thrStrobe_t           strobe
);

  localparam int REG_W = 2 * NIB_W;
  localparam int LVL_W = NIB_W + STEP_LOG2;
  localparam int N_LVL = 2;   // index 0: halt, index 1: resume

  logic [REG_W-1:0] ctrlQ;
  logic             wrAllowed;
  logic [N_LVL-1:0][CNT_W-1:0] levelBytes;

  assign wrAllowed = wrEn & extEnable & modemSel;

  always_ff @(posedge clk) begin
    if (!rstN)          ctrlQ <= '0;
    else if (wrAllowed) ctrlQ <= wrData;
  end

  // Each code is scaled by the step size into a byte level
  for (genvar g = 0; g < N_LVL; g++) begin : gLevel
    logic [LVL_W-1:0] scaled;
    assign scaled        = {ctrlQ[g*NIB_W +: NIB_W], {STEP_LOG2{1'b0}}};
    assign levelBytes[g] = CNT_W'(scaled);
  end

  assign strobe.reachHalt   = (rxCount >= levelBytes[0]);
  assign strobe.reachResume = (rxCount <= levelBytes[1]);
  assign ctrlValue          = ctrlQ;

endmodule

// File: rtl/rx_flow_thresh_ctl.sv
module rx_flow_thresh_ctl
  import rx_flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flowEn,
  input  thrStrobe_t strobe,
  output logic       haltReq,
  output logic       stopPulse,
  output logic       resumePulse
);

  flowState_t stateQ, stateD;
  logic       stopD, resumeD;
  logic       stopQ, resumeQ;

  always_comb begin
    stateD  = stateQ;
    stopD   = 1'b0;
    resumeD = 1'b0;
    if (!flowEn) begin
      stateD = FLOW_RUN;
    end else begin
      case (stateQ)
        FLOW_RUN: if (strobe.reachHalt) begin
          stateD = FLOW_HOLD;
          stopD  = 1'b1;
        end
        FLOW_HOLD: if (strobe.reachResume) begin
          stateD  = FLOW_RUN;
          resumeD = 1'b1;
        end
        default: stateD = FLOW_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= FLOW_RUN;
      stopQ   <= 1'b0;
      resumeQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      stopQ   <= stopD;
      resumeQ <= resumeD;
    end
  end

  assign haltReq     = (stateQ == FLOW_HOLD);
  assign stopPulse   = stopQ;
  assign resumePulse = resumeQ;

endmodule

// File: rtl/rx_flow_gate.sv
module rx_flow_gate
  import rx_flow_pkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int NIB_W     = 4,
  parameter int STEP_LOG2 = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2*NIB_W-1:0]   wrData,
  input  logic                 extEnable,
  input  logic                 modemSel,
  input  logic [CNT_W-1:0]     rxCount,
  input  logic                 flowEn,
  output logic [2*NIB_W-1:0]   ctrlValue,
  output logic                 haltReq,
  output logic                 stopPulse,
  output logic                 resumePulse
);

  thrStrobe_t strobe;

  rx_flow_thresh_dp #(
    .CNT_W(CNT_W), .NIB_W(NIB_W), .STEP_LOG2(STEP_LOG2)
  ) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .extEnable(extEnable), .modemSel(modemSel), .rxCount(rxCount),
    .ctrlValue(ctrlValue), .strobe(strobe)
  );

  rx_flow_thresh_ctl uCtl (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .strobe(strobe),
    .haltReq(haltReq), .stopPulse(stopPulse), .resumePulse(resumePulse)
  );

endmodule

// File: rtl/rx_flow_gate_chk.sv
module rx_flow_gate_chk #(
  parameter int CNT_W     = 7,
  parameter int NIB_W     = 4,
  parameter int STEP_LOG2 = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [2*NIB_W-1:0] wrData,
  input logic               extEnable,
  input logic               modemSel,
  input logic [CNT_W-1:0]   rxCount,
  input logic               flowEn,
  input logic [2*NIB_W-1:0] ctrlValue,
  input logic               haltReq,
  input logic               stopPulse,
  input logic               resumePulse
);

  logic [CNT_W-1:0] haltLvl, resumeLvl;
  assign haltLvl   = CNT_W'({ctrlValue[NIB_W-1:0], {STEP_LOG2{1'b0}}});
  assign resumeLvl = CNT_W'({ctrlValue[2*NIB_W-1:NIB_W], {STEP_LOG2{1'b0}}});

  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && extEnable && modemSel) |=> (ctrlValue == $past(wrData))); // R2
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(extEnable && modemSel)) |=> $stable(ctrlValue)); // R3
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && !haltReq && rxCount >= haltLvl) |=> (haltReq && stopPulse)); // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && haltReq && rxCount > resumeLvl) |=> (haltReq && !stopPulse)); // R5
  AST_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    (flowEn && haltReq && rxCount <= resumeLvl) |=> (!haltReq && resumePulse)); // R5
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |=> (!haltReq && !resumePulse && !stopPulse)); // R6
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(stopPulse && resumePulse)); // R4

endmodule

bind rx_flow_gate rx_flow_gate_chk #(
  .CNT_W(CNT_W), .NIB_W(NIB_W), .STEP_LOG2(STEP_LOG2)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .extEnable(extEnable), .modemSel(modemSel), .rxCount(rxCount),
  .flowEn(flowEn), .ctrlValue(ctrlValue), .haltReq(haltReq),
  .stopPulse(stopPulse), .resumePulse(resumePulse)
);

// File: tb/tb_rx_flow_gate.sv
module tb_rx_flow_gate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       extEnable = 1'b0;
  logic       modemSel = 1'b0;
  logic [6:0] rxCount = '0;
  logic       flowEn = 1'b0;
  logic [7:0] ctrlValue;
  logic       haltReq, stopPulse, resumePulse;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model state
  int  modelHalt = 0;    // halt code
  int  modelResume = 0;  // resume code
  bit  expHalt = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  rx_flow_gate dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .extEnable(extEnable), .modemSel(modemSel), .rxCount(rxCount),
    .flowEn(flowEn), .ctrlValue(ctrlValue), .haltReq(haltReq),
    .stopPulse(stopPulse), .resumePulse(resumePulse)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] d, input logic ext, input logic mdm);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; extEnable = ext; modemSel = mdm;
    @(negedge clk);
    wrEn = 1'b0; extEnable = 1'b0; modemSel = 1'b0;
    if (ext && mdm) begin
      modelHalt   = int'(d[3:0]);
      modelResume = int'(d[7:4]);
    end
  endtask

  task automatic applyStep(input int c, input bit en, input string req);
    bit nxt;
    bit expStop, expRes;
    @(negedge clk);
    rxCount = 7'(c);
    flowEn  = en;
    if (!en)                                 nxt = 1'b0;
    else if (!expHalt && c >= 4*modelHalt)   nxt = 1'b1;
    else if (expHalt && c <= 4*modelResume)  nxt = 1'b0;
    else                                     nxt = expHalt;
    expStop = !expHalt && nxt;
    expRes  = expHalt && !nxt && en;
    expHalt = nxt;
    @(posedge clk);
    #1;
    check(req, "haltReq", int'(haltReq), int'(expHalt));
    check(req, "stopPulse", int'(stopPulse), int'(expStop));
    check(req, "resumePulse", int'(resumePulse), int'(expRes));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", "ctrlValue", int'(ctrlValue), 0);
    check("R1", "haltReq", int'(haltReq), 0);
    check("R1", "stopPulse", int'(stopPulse), 0);
    check("R1", "resumePulse", int'(resumePulse), 0);

    // R2 accepted write, R3 ignored writes
    writeReg(8'h3A, 1'b1, 1'b1);
    check("R2", "ctrlValue", int'(ctrlValue), 'h3A);
    writeReg(8'hC5, 1'b0, 1'b1);
    check("R3", "ctrlValue ext low", int'(ctrlValue), 'h3A);
    writeReg(8'hC5, 1'b1, 1'b0);
    check("R3", "ctrlValue modem low", int'(ctrlValue), 'h3A);
    writeReg(8'hC5, 1'b0, 1'b0);
    check("R3", "ctrlValue both low", int'(ctrlValue), 'h3A);

    // R4/R5 sweep over every ordered code pair, ramp up then down
    for (int h = 1; h < 16; h++) begin
      for (int r = 0; r < h; r++) begin
        applyStep(0, 1'b0, "R6");
        writeReg(8'((r << 4) | h), 1'b1, 1'b1);
        check("R2", "ctrlValue sweep", int'(ctrlValue), (r << 4) | h);
        for (int c = 0; c <= 64; c++) applyStep(c, 1'b1, "R4");
        for (int c = 64; c >= 0; c--) applyStep(c, 1'b1, "R5");
      end
    end

    // R6 disable while halted, then re-enable between levels
    applyStep(0, 1'b0, "R6");
    writeReg(8'h28, 1'b1, 1'b1);   // halt 32, resume 8
    applyStep(40, 1'b1, "R6");
    check("R6", "halted before disable", int'(haltReq), 1);
    applyStep(40, 1'b0, "R6");
    applyStep(20, 1'b1, "R6");
    applyStep(20, 1'b1, "R6");
    check("R6", "stays released", int'(haltReq), 0);

    // R7 misordered codes: halt 8, resume 20, count 10
    applyStep(0, 1'b0, "R7");
    writeReg(8'h52, 1'b1, 1'b1);
    applyStep(10, 1'b1, "R7");
    check("R7", "first set", int'(haltReq), 1);
    applyStep(10, 1'b1, "R7");
    check("R7", "released next", int'(haltReq), 0);
    applyStep(10, 1'b1, "R7");
    check("R7", "set again", int'(haltReq), 1);
    applyStep(0, 1'b0, "R7");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule